// File: doc/BRIEF.md
# Converter Control and Status Register Block

This block is the digital register front end of an eight-input successive-approximation converter. A CPU reaches two byte-wide locations over a plain bus with read and write strobes. Address 0 is a control/status byte. Address 1 is the result of the last conversion. The block drives a conversion engine with a one-cycle start pulse and a channel number. It takes the engine's done pulse and result back into the data location.

Completion is reported in one of two ways, chosen by the interrupt-enable bit. With interrupts off, a sticky completion flag in the control/status byte is set and held until software reads the data location. With interrupts on, that flag is never set and reads as zero, and the interrupt request line is raised instead. Reading the data location clears whichever of the two was raised.

Writing a channel number to the control byte aborts any running conversion and starts a new one. The all-ones code powers the converter down, and codes 8 to 30 are reserved and start nothing. The continuous bit makes the engine restart on the same channel after every completion.

Top module: `adc_ctrl_regs`

## Requirements
- R1: After reset the control byte reads 8'h1F (flag 0, interrupt enable 0, continuous 0, channel select 5'b11111). The data byte reads 8'h00, and irq and eng_start are 0.
- R2: The control byte layout is: bit 7 completion flag, bit 6 interrupt enable, bit 5 continuous enable, bits 4:0 channel select. A write to address 0 sets bits 6:0 to the written value.
- R3: Bit 7 of a write to address 0 is ignored. The flag reads back unchanged by the write.
- R4: With interrupt enable 0, a done pulse sets the completion flag from the next cycle on and loads eng_result into the data byte.
- R5: The completion flag stays set until a read of address 1. That read returns the data, and the flag reads 0 from the next cycle.
- R6: With interrupt enable 1, bit 7 of the control byte always reads 0. A done pulse asserts irq from the next cycle, and a read of address 1 deasserts it from the next cycle.
- R7: A write to address 0 with channel select 0 to 7 gives a one-cycle eng_start in the next cycle. eng_chan equals the written channel, and the new start aborts any conversion in progress.
- R8: A write to address 0 with channel select 8 to 31 (31 = power-down) gives no eng_start.
- R9: With continuous enable 1 and a valid channel, each done pulse gives eng_start in the next cycle on the same channel. With continuous enable 0, a done pulse starts nothing.
- R10: A done pulse in the same cycle as a read of address 1 leaves the flag (or irq) set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 1 | 0 = control/status byte, 1 = data byte |
| cpu_wr | input | 1 | Write strobe, one cycle |
| cpu_rd | input | 1 | Read strobe, one cycle |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, combinational from addr |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_chan | output | 3 | Channel for the engine |
| eng_done | input | 1 | One-cycle completion pulse from the engine |
| eng_result | input | 8 | Conversion result, valid with eng_done |
| irq | output | 1 | Interrupt request, level |

## Verification
The properties assume that eng_done is a single-cycle pulse and that the CPU strobes last exactly one cycle. They also assume that eng_chan is only meaningful while eng_start is high. The stub engine in the bench raises done only after a fixed latency following a start, and every bus access in the bench is a one-cycle strobe. Writes that switch modes are placed right after an observed start, so a control write never lands on a done cycle. The one deliberate overlap of done and a data read exercises the set-wins rule.

// File: rtl/adc_regs_pkg.sv
// Shared constants and field layout for the converter register block.
// Assumes an 8-bit CPU bus; layout is fixed by software-visible bit positions.
package adc_regs_pkg;
    localparam int BUS_W   = 8;
    localparam int SEL_W   = 5;
    localparam int ADDR_CTRL = 0;
    localparam int ADDR_DATA = 1;
    localparam logic [SEL_W-1:0] SEL_OFF = '1;

    typedef struct packed {
        logic             flag;
        logic             ien;
        logic             cont;
        logic [SEL_W-1:0] sel;
    } ctrl_byte_t;
endpackage

// File: rtl/adc_csr.sv
// Holds the writable control fields (interrupt enable, continuous, channel select).
// Assumes wr_en is a one-cycle strobe; bit 7 of wdata is never stored here.
module adc_csr
    import adc_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [6:0]       wdata,
    output logic             ien_q,
    output logic             cont_q,
    output logic [SEL_W-1:0] sel_q
);
    // Load writable fields on a control write; reset to powered-down state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q  <= 1'b0;
            cont_q <= 1'b0;
            sel_q  <= SEL_OFF;
        end else if (wr_en) begin
            ien_q  <= wdata[6];
            cont_q <= wdata[5];
            sel_q  <= wdata[SEL_W-1:0];
        end
    end
endmodule

// File: rtl/adc_start_seq.sv
// Generates the engine start pulse from control writes and continuous restarts.
// Assumes done is a one-cycle pulse; a control write wins over a same-cycle restart.
module adc_start_seq
    import adc_regs_pkg::*;
#(
    parameter int NUM_CH = 8,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic             done,
    input  logic             cont_q,
    input  logic [SEL_W-1:0] sel_q,
    output logic             start_q,
    output logic [CH_W-1:0]  chan
);
    localparam logic [SEL_W-1:0] NCH = SEL_W'(NUM_CH);

    logic wr_valid;
    logic cur_valid;
    logic start_d;

    // Decide whether the next cycle carries a start.
    always_comb begin
        wr_valid  = wr_sel < NCH;
        cur_valid = sel_q < NCH;
        if (ctrl_wr) start_d = wr_valid;
        else         start_d = done && cont_q && cur_valid;
    end

    // Register the start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= start_d;
    end

    assign chan = sel_q[CH_W-1:0];
endmodule

// File: rtl/adc_result_path.sv
// Captures results and keeps the completion flag and interrupt request.
// Assumes done is a one-cycle pulse; a set on done wins over a clear by read.
module adc_result_path
    import adc_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done,
    input  logic [BUS_W-1:0] result,
    input  logic             ien_q,
    input  logic             data_rd,
    output logic [BUS_W-1:0] data_q,
    output logic             flag_q,
    output logic             irq_q
);
    // Load the data byte on every completion.
    always_ff @(posedge clk) begin
        if (!rst_n)    data_q <= '0;
        else if (done) data_q <= result;
    end

    // Set the polled flag or the interrupt by mode; clear both on data read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (done && !ien_q)  flag_q <= 1'b1;
            else if (data_rd)    flag_q <= 1'b0;
            if (done && ien_q)   irq_q  <= 1'b1;
            else if (data_rd)    irq_q  <= 1'b0;
        end
    end
endmodule

// File: rtl/adc_ctrl_regs.sv
// Top of the converter register block: bus decode, read mux, engine handshake.
// Assumes single-cycle bus strobes and a combinational read path.
module adc_ctrl_regs
    import adc_regs_pkg::*;
#(
    parameter int NUM_CH = 8,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_addr,
    input  logic             cpu_wr,
    input  logic             cpu_rd,
    input  logic [BUS_W-1:0] cpu_wdata,
    output logic [BUS_W-1:0] cpu_rdata,
    output logic             eng_start,
    output logic [CH_W-1:0]  eng_chan,
    input  logic             eng_done,
    input  logic [BUS_W-1:0] eng_result,
    output logic             irq
);
    logic             ctrl_wr;
    logic             data_rd;
    logic             ien_q;
    logic             cont_q;
    logic [SEL_W-1:0] sel_q;
    logic [BUS_W-1:0] data_q;
    logic             flag_q;
    logic             unused_flag_wr;
    ctrl_byte_t       ctrl_view;

    // Decode strobes by address.
    always_comb begin
        ctrl_wr = cpu_wr && (cpu_addr == 1'(ADDR_CTRL));
        data_rd = cpu_rd && (cpu_addr == 1'(ADDR_DATA));
    end

    assign unused_flag_wr = cpu_wdata[7];

    adc_csr u_csr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (ctrl_wr),
        .wdata  (cpu_wdata[6:0]),
        .ien_q  (ien_q),
        .cont_q (cont_q),
        .sel_q  (sel_q)
    );

    adc_start_seq #(.NUM_CH(NUM_CH)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (ctrl_wr),
        .wr_sel  (cpu_wdata[SEL_W-1:0]),
        .done    (eng_done),
        .cont_q  (cont_q),
        .sel_q   (sel_q),
        .start_q (eng_start),
        .chan    (eng_chan)
    );

    adc_result_path u_res (
        .clk     (clk),
        .rst_n   (rst_n),
        .done    (eng_done),
        .result  (eng_result),
        .ien_q   (ien_q),
        .data_rd (data_rd),
        .data_q  (data_q),
        .flag_q  (flag_q),
        .irq_q   (irq)
    );

    // Assemble the control byte; the flag is masked while interrupts are on.
    always_comb begin
        ctrl_view.flag = flag_q && !ien_q;
        ctrl_view.ien  = ien_q;
        ctrl_view.cont = cont_q;
        ctrl_view.sel  = sel_q;
        cpu_rdata = (cpu_addr == 1'(ADDR_CTRL)) ? BUS_W'(ctrl_view) : data_q;
    end
endmodule

// File: rtl/adc_ctrl_regs_chk.sv
// Property checker for adc_ctrl_regs, attached by bind.
// Assumes one-cycle strobes and one-cycle done pulses.
module adc_ctrl_regs_chk #(
    parameter int NUM_CH = 8,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cpu_addr,
    input logic            cpu_wr,
    input logic            cpu_rd,
    input logic [4:0]      wsel,
    input logic            rd_bit7,
    input logic            eng_start,
    input logic [CH_W-1:0] eng_chan,
    input logic            eng_done,
    input logic            irq,
    input logic            ien_q,
    input logic            cont_q,
    input logic [4:0]      sel_q
);
    localparam logic [4:0] NCH = 5'(NUM_CH);

    logic cwr;
    assign cwr = cpu_wr && !cpu_addr;

    AST_START_ON_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (cwr && wsel < NCH) |=> (eng_start && eng_chan == $past(wsel[CH_W-1:0]))); // R7
    AST_NO_START_RESV: assert property (@(posedge clk) disable iff (!rst_n)
        (cwr && wsel >= NCH) |=> !eng_start); // R8
    AST_CONT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && cont_q && sel_q < NCH && !cwr) |=> eng_start); // R9
    AST_NO_RESTART_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && !cont_q && !cwr) |=> !eng_start); // R9
    AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && ien_q) |=> irq); // R6
    AST_IRQ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_addr && !eng_done) |=> !irq); // R6
    AST_FLAG_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q && !cpu_addr) |-> !rd_bit7); // R6
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && !ien_q && !cwr) |=> (cpu_addr || rd_bit7)); // R4
endmodule

bind adc_ctrl_regs adc_ctrl_regs_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_wr    (cpu_wr),
    .cpu_rd    (cpu_rd),
    .wsel      (cpu_wdata[4:0]),
    .rd_bit7   (cpu_rdata[7]),
    .eng_start (eng_start),
    .eng_chan  (eng_chan),
    .eng_done  (eng_done),
    .irq       (irq),
    .ien_q     (ien_q),
    .cont_q    (cont_q),
    .sel_q     (sel_q)
);

// File: tb/adc_ctrl_regs_tb.sv
// Scoreboard bench: write tasks queue expected starts, a monitor pops them.
module adc_ctrl_regs_tb;
    localparam int LAT = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_addr = 1'b0;
    logic       cpu_wr = 1'b0;
    logic       cpu_rd = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       eng_start;
    logic [2:0] eng_chan;
    logic       eng_done = 1'b0;
    logic [7:0] eng_result = '0;
    logic       irq;

    int vectors = 0;
    int fails = 0;
    logic [2:0] exp_q[$];
    logic       exp_cont = 1'b0;
    logic [4:0] exp_sel = 5'h1F;
    logic [7:0] stub_last = '0;
    logic [4:0] stub_seq = '0;
    logic [2:0] stub_ch = '0;
    int         stub_cnt = 0;
    logic       stub_busy = 1'b0;
    logic [7:0] v;

    always #2 clk = ~clk;

    adc_ctrl_regs u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .eng_start(eng_start), .eng_chan(eng_chan), .eng_done(eng_done),
        .eng_result(eng_result), .irq(irq)
    );

    // Behavioural engine: fixed latency, restarted by any start.
    always @(posedge clk) begin
        eng_done <= 1'b0;
        if (eng_start) begin
            stub_busy <= 1'b1;
            stub_cnt  <= LAT;
            stub_ch   <= eng_chan;
        end else if (stub_busy) begin
            if (stub_cnt == 1) begin
                eng_done   <= 1'b1;
                eng_result <= {stub_ch, stub_seq};
                stub_last  <= {stub_ch, stub_seq};
                stub_seq   <= stub_seq + 5'd1;
                stub_busy  <= 1'b0;
            end else begin
                stub_cnt <= stub_cnt - 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Monitor: pop an expected channel for each start; queue restarts in continuous mode.
    always @(negedge clk) begin
        if (rst_n) begin
            if (eng_start) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected start", {5'd0, eng_chan}, 8'h00);
                end else begin
                    logic [2:0] e;
                    e = exp_q.pop_front();
                    check(eng_chan == e, "R7 start channel", {5'd0, eng_chan}, {5'd0, e});
                end
            end
            if (eng_done && exp_cont && exp_sel < 5'd8) exp_q.push_back(exp_sel[2:0]);
        end
    end

    task automatic wr_ctrl(input logic [7:0] d);
        @(negedge clk);
        cpu_addr = 1'b0; cpu_wdata = d; cpu_wr = 1'b1;
        exp_cont = d[5]; exp_sel = d[4:0];
        if (d[4:0] < 5'd8) exp_q.push_back(d[2:0]);
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] r);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        #1 r = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (!eng_done) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(irq == 1'b0 && eng_start == 1'b0, "R1 irq/start", {6'd0, irq, eng_start}, 8'h00);
        rd(1'b0, v); check(v == 8'h1F, "R1 ctrl reset", v, 8'h1F);
        rd(1'b1, v); check(v == 8'h00, "R1 data reset", v, 8'h00);

        // Reserved channel, flag bit written as 1
        wr_ctrl(8'hFE);
        rd(1'b0, v); check(v == 8'h7E, "R2 R3 R8 readback", v, 8'h7E);
        wr_ctrl(8'h89);
        rd(1'b0, v); check(v == 8'h09, "R3 R8 readback", v, 8'h09);

        // Polled one-shot
        wr_ctrl(8'h03);
        wait_done();
        rd(1'b0, v); check(v == 8'h83, "R4 flag set", v, 8'h83);
        check(irq == 1'b0, "R6 no irq when polled", {7'd0, irq}, 8'h00);
        rd(1'b0, v); check(v == 8'h83, "R5 flag held", v, 8'h83);
        rd(1'b1, v); check(v == stub_last, "R4 data", v, stub_last);
        rd(1'b0, v); check(v == 8'h03, "R5 flag cleared", v, 8'h03);
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R9 one-shot idle", 8'(exp_q.size()), 8'h00);

        // Interrupt mode
        wr_ctrl(8'h45);
        wait_done();
        @(negedge clk);
        check(irq == 1'b1, "R6 irq set", {7'd0, irq}, 8'h01);
        rd(1'b0, v); check(v == 8'h45, "R6 flag masked", v, 8'h45);
        rd(1'b1, v); check(v == stub_last, "R6 data", v, stub_last);
        check(irq == 1'b0, "R6 irq cleared", {7'd0, irq}, 8'h00);

        // Continuous mode: three starts then stop
        wr_ctrl(8'h26);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            while (!eng_start) @(negedge clk);
        end
        wr_ctrl(8'h1F);
        repeat (30) @(negedge clk);
        check(exp_q.size() == 0, "R9 continuous restarts", 8'(exp_q.size()), 8'h00);
        rd(1'b1, v); check(v[7:5] == 3'd6, "R9 same channel", {5'd0, v[7:5]}, 8'h06);

        // Abort by a new write
        wr_ctrl(8'h01);
        wr_ctrl(8'h07);
        wait_done();
        rd(1'b1, v); check(v[7:5] == 3'd7, "R7 abort restart", {5'd0, v[7:5]}, 8'h07);

        // Done coincides with data read
        wr_ctrl(8'h02);
        wait_done();
        cpu_addr = 1'b1; cpu_rd = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0;
        rd(1'b0, v); check(v == 8'h82, "R10 set wins", v, 8'h82);
        rd(1'b1, v);
        rd(1'b0, v); check(v == 8'h02, "R5 cleared after R10", v, 8'h02);

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R7 all starts seen", 8'(exp_q.size()), 8'h00);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule